// File: doc/BRIEF.md
# Split-Route Interrupt Controller Register Block

This block gathers 32 level-sensitive interrupt lines and drives two request outputs: a normal request and a fast request. Software reaches it through a simple word-addressed bus. One request costs one clock cycle. It has a request strobe, a write flag, a privilege flag, a 4-bit word address and 32-bit write data. Read data comes back one cycle after the request.

Each source has an enable bit. Software can only set enable bits through a write-one-to-set location and only clear them through a write-one-to-clear location, so no read-modify-write is needed. A route mask sends each enabled source to either the normal output or the fast output. Software can read the raw line levels and the two masked status words. A guard bit can limit register access to privileged requests.

Every bus request is sorted into one of four access kinds: IDLE (no request), READ, WRITE, and DENY. DENY is any request from a non-privileged master while the guard is on. The transitions are per-cycle. A request with the write flag becomes WRITE, or DENY if it is blocked. A request without the write flag becomes READ, or DENY if it is blocked. No request gives IDLE.

Top module: `irq_split_ctrl`

## Requirements
- R1: A read of word offset 2 returns the current level of each of the 32 source lines, bit n for source n, before any masking.
- R2: A read of word offset 0 returns lines AND enable AND NOT route mask.
- R3: A read of word offset 1 returns lines AND enable AND route mask.
- R4: Writing offset 4 sets every enable bit whose write-data bit is 1 and leaves the other enable bits unchanged. A read of offset 4 returns the enable mask.
- R5: Writing offset 5 clears every enable bit whose write-data bit is 1 and leaves the other enable bits unchanged. A read of offset 5 returns zero.
- R6: Offset 3 holds the route mask. Writes load it and reads return it. A 1 bit sends that source to the fast output, and a 0 bit sends it to the normal output.
- R7: `irq_norm_o` is the OR of the normal status bits and `irq_fast_o` is the OR of the fast status bits. Each is registered, so it follows the inputs one clock edge later. With no enable bits set, both outputs are low.
- R8: After reset the enable mask, route mask, guard bit and both request outputs are all zero.
- R9: Offset 8 bit 0 is the guard bit. While it is 1, a request with `bus_priv` low changes no register, including the guard itself, and its read returns zero. Privileged requests keep full access.
- R10: Reads of offsets 6, 7 and 9 to 15 return zero. Writes to offsets 0, 1 and 2 have no effect.
- R11: Status is level-sensitive. A status bit and its output request fall once the source line drops or its enable bit is cleared. No latched state remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 1 | Bus request strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_priv | input | 1 | 1 = privileged access |
| bus_addr | input | 4 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read request, zero otherwise |
| src_lines | input | 32 | Level-sensitive interrupt source lines |
| irq_norm_o | output | 1 | Registered normal interrupt request |
| irq_fast_o | output | 1 | Registered fast interrupt request |

## Verification
Single-bit set and clear sweeps over all 32 positions separate true write-one-to-set and write-one-to-clear behaviour from plain loads, and show that zero bits leave other enables alone. One-hot routing of each source in both route settings shows which output each bit reaches. The line dropping and the enable being cleared are tried separately, so level-sensitive clearing cannot be confused with a sticky latch. Pseudo-random line, enable and route words drive all three status words at once. These words catch any mix-up between the AND-NOT and AND terms. Guard on/off sequences with both privilege levels, plus unmapped and read-only offsets, expose any leaked write or non-zero read.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int unsigned SRC_COUNT   = 32;
    localparam int unsigned WORD_ADDR_W = 4;

    // Word offsets decoded by software drivers
    localparam int unsigned OFS_NSTAT = 0;
    localparam int unsigned OFS_FSTAT = 1;
    localparam int unsigned OFS_RAW   = 2;
    localparam int unsigned OFS_ROUTE = 3;
    localparam int unsigned OFS_ENSET = 4;
    localparam int unsigned OFS_ENCLR = 5;
    localparam int unsigned OFS_GUARD = 8;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_DENY  = 2'd3
    } acc_kind_e;
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int unsigned NSRC = SRC_COUNT,
    parameter int unsigned AW   = WORD_ADDR_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  acc_kind_e       kind,
    input  logic [AW-1:0]   addr,
    input  logic [NSRC-1:0] wdata,
    output logic [NSRC-1:0] en_mask,
    output logic [NSRC-1:0] route_mask,
    output logic            guard_on
);
    localparam logic [AW-1:0] A_ROUTE = AW'(OFS_ROUTE);
    localparam logic [AW-1:0] A_ENSET = AW'(OFS_ENSET);
    localparam logic [AW-1:0] A_ENCLR = AW'(OFS_ENCLR);
    localparam logic [AW-1:0] A_GUARD = AW'(OFS_GUARD);

    logic [NSRC-1:0] en_q, en_d;
    logic [NSRC-1:0] route_q, route_d;
    logic            guard_q, guard_d;

    always_comb begin
        en_d    = en_q;
        route_d = route_q;
        guard_d = guard_q;
        if (kind == ACC_WRITE) begin
            case (addr)
                A_ENSET: en_d    = en_q | wdata;
                A_ENCLR: en_d    = en_q & ~wdata;
                A_ROUTE: route_d = wdata;
                A_GUARD: guard_d = wdata[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= '0;
            route_q <= '0;
            guard_q <= 1'b0;
        end else begin
            en_q    <= en_d;
            route_q <= route_d;
            guard_q <= guard_d;
        end
    end

    assign en_mask    = en_q;
    assign route_mask = route_q;
    assign guard_on   = guard_q;

    // R4: set bits land, R5: cleared bits drop
    assert_enset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_WRITE && addr == A_ENSET) |=> ((en_q & $past(wdata)) == $past(wdata)));
    assert_enclr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_WRITE && addr == A_ENCLR) |=> ((en_q & $past(wdata)) == '0));
    assert_deny_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_DENY) |=> ($stable(en_q) && $stable(route_q) && $stable(guard_q)));
endmodule

// File: rtl/irqc_route.sv
module irqc_route
    import irqc_pkg::*;
#(
    parameter int unsigned NSRC = SRC_COUNT
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] lines,
    input  logic [NSRC-1:0] en_mask,
    input  logic [NSRC-1:0] route_mask,
    output logic [NSRC-1:0] norm_stat,
    output logic [NSRC-1:0] fast_stat,
    output logic            irq_norm,
    output logic            irq_fast
);
    logic [NSRC-1:0] live;

    always_comb begin
        live      = lines & en_mask;
        norm_stat = live & ~route_mask;
        fast_stat = live & route_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_norm <= 1'b0;
            irq_fast <= 1'b0;
        end else begin
            irq_norm <= |norm_stat;
            irq_fast <= |fast_stat;
        end
    end

    // R7: nothing enabled means both requests low next cycle
    assert_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_mask == '0) |=> (!irq_norm && !irq_fast));
    // R11: no line asserted means no request next cycle
    assert_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (lines == '0) |=> (!irq_norm && !irq_fast));
endmodule

// File: rtl/irqc_rdmux.sv
module irqc_rdmux
    import irqc_pkg::*;
#(
    parameter int unsigned NSRC = SRC_COUNT,
    parameter int unsigned AW   = WORD_ADDR_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  acc_kind_e       kind,
    input  logic [AW-1:0]   addr,
    input  logic [NSRC-1:0] lines,
    input  logic [NSRC-1:0] norm_stat,
    input  logic [NSRC-1:0] fast_stat,
    input  logic [NSRC-1:0] en_mask,
    input  logic [NSRC-1:0] route_mask,
    input  logic            guard_on,
    output logic [NSRC-1:0] rdata
);
    localparam logic [AW-1:0] A_NSTAT = AW'(OFS_NSTAT);
    localparam logic [AW-1:0] A_FSTAT = AW'(OFS_FSTAT);
    localparam logic [AW-1:0] A_RAW   = AW'(OFS_RAW);
    localparam logic [AW-1:0] A_ROUTE = AW'(OFS_ROUTE);
    localparam logic [AW-1:0] A_ENSET = AW'(OFS_ENSET);
    localparam logic [AW-1:0] A_GUARD = AW'(OFS_GUARD);

    logic [NSRC-1:0] sel_word;
    logic            mapped;

    always_comb begin
        sel_word = '0;
        mapped   = 1'b1;
        case (addr)
            A_NSTAT: sel_word = norm_stat;
            A_FSTAT: sel_word = fast_stat;
            A_RAW:   sel_word = lines;
            A_ROUTE: sel_word = route_mask;
            A_ENSET: sel_word = en_mask;
            A_GUARD: sel_word = {{(NSRC-1){1'b0}}, guard_on};
            default: mapped   = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (kind == ACC_READ) begin
            rdata <= sel_word;
        end else begin
            rdata <= '0;
        end
    end

    // R10: unmapped offsets read zero; R9: denied reads return zero
    assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_READ && !mapped) |=> (rdata == '0));
    assert_denyrd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_DENY) |=> (rdata == '0));
endmodule

// File: rtl/irq_split_ctrl.sv
module irq_split_ctrl
    import irqc_pkg::*;
#(
    parameter int unsigned NSRC = SRC_COUNT,
    parameter int unsigned AW   = WORD_ADDR_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_req,
    input  logic            bus_wr,
    input  logic            bus_priv,
    input  logic [AW-1:0]   bus_addr,
    input  logic [NSRC-1:0] bus_wdata,
    output logic [NSRC-1:0] bus_rdata,
    input  logic [NSRC-1:0] src_lines,
    output logic            irq_norm_o,
    output logic            irq_fast_o
);
    acc_kind_e       kind;
    logic            blocked;
    logic [NSRC-1:0] en_mask, route_mask, norm_stat, fast_stat;
    logic            guard_on;

    // Per-cycle access classification
    always_comb begin
        blocked = guard_on && !bus_priv;
        unique case ({bus_req, bus_wr})
            2'b10:   kind = blocked ? ACC_DENY : ACC_READ;
            2'b11:   kind = blocked ? ACC_DENY : ACC_WRITE;
            default: kind = ACC_IDLE;
        endcase
    end

    irqc_regs #(.NSRC(NSRC), .AW(AW)) regs_i (
        .clk(clk), .rst_n(rst_n), .kind(kind), .addr(bus_addr),
        .wdata(bus_wdata), .en_mask(en_mask), .route_mask(route_mask),
        .guard_on(guard_on)
    );

    irqc_route #(.NSRC(NSRC)) route_i (
        .clk(clk), .rst_n(rst_n), .lines(src_lines), .en_mask(en_mask),
        .route_mask(route_mask), .norm_stat(norm_stat), .fast_stat(fast_stat),
        .irq_norm(irq_norm_o), .irq_fast(irq_fast_o)
    );

    irqc_rdmux #(.NSRC(NSRC), .AW(AW)) rdmux_i (
        .clk(clk), .rst_n(rst_n), .kind(kind), .addr(bus_addr),
        .lines(src_lines), .norm_stat(norm_stat), .fast_stat(fast_stat),
        .en_mask(en_mask), .route_mask(route_mask), .guard_on(guard_on),
        .rdata(bus_rdata)
    );

    // R9: a blocked write leaves the guard as it was
    assert_guard_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_wr && guard_on && !bus_priv) |=> guard_on);
endmodule

// File: tb/irq_split_ctrl_tb.sv
`timescale 1ns/1ps
module irq_split_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_wr = 1'b0, bus_priv = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata, src_lines = '0;
    logic        irq_norm_o, irq_fast_o;

    int checks = 0;
    int fails  = 0;
    logic [31:0] en_m = '0, rt_m = '0;
    logic        gd_m = 1'b0;

    always #2.5 clk = ~clk;

    irq_split_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
        .bus_priv(bus_priv), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .src_lines(src_lines),
        .irq_norm_o(irq_norm_o), .irq_fast_o(irq_fast_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic p);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_priv = p;
        @(negedge clk);
        bus_req = 1'b0; bus_wr = 1'b0;
        if (!gd_m || p) begin
            case (a)
                4'd3: rt_m = d;
                4'd4: en_m = en_m | d;
                4'd5: en_m = en_m & ~d;
                4'd8: gd_m = d[0];
                default: ;
            endcase
        end
    endtask

    task automatic rd(input logic [3:0] a, input logic p, output logic [31:0] r);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_priv = p;
        @(negedge clk);
        r = bus_rdata;
        bus_req = 1'b0;
    endtask

    task automatic chk_irq(input string tag);
        @(negedge clk);
        chk({tag, " norm"}, {31'b0, irq_norm_o}, {31'b0, |(src_lines & en_m & ~rt_m)});
        chk({tag, " fast"}, {31'b0, irq_fast_o}, {31'b0, |(src_lines & en_m & rt_m)});
    endtask

    task automatic chk_status(input string tag);
        logic [31:0] r;
        rd(4'd2, 1'b1, r); chk({tag, " R1 raw"}, r, src_lines);
        rd(4'd0, 1'b1, r); chk({tag, " R2 norm"}, r, src_lines & en_m & ~rt_m);
        rd(4'd1, 1'b1, r); chk({tag, " R3 fast"}, r, src_lines & en_m & rt_m);
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] r, seed;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8 reset state
        chk("R8 irq_norm", {31'b0, irq_norm_o}, 32'h0);
        chk("R8 irq_fast", {31'b0, irq_fast_o}, 32'h0);
        rd(4'd4, 1'b1, r); chk("R8 enable", r, 32'h0);
        rd(4'd3, 1'b1, r); chk("R8 R6 route", r, 32'h0);
        rd(4'd8, 1'b1, r); chk("R8 guard", r, 32'h0);

        // R4 single-bit set sweep
        for (int i = 0; i < 32; i++) begin
            wr(4'd4, 32'h1 << i, 1'b1);
            rd(4'd4, 1'b1, r); chk("R4 set sweep", r, en_m);
        end
        wr(4'd4, 32'h0, 1'b1);
        rd(4'd4, 1'b1, r); chk("R4 zero write", r, 32'hFFFF_FFFF);
        // R5 single-bit clear sweep
        for (int i = 0; i < 32; i += 1) begin
            wr(4'd5, 32'h1 << i, 1'b1);
            rd(4'd4, 1'b1, r); chk("R5 clear sweep", r, en_m);
        end
        wr(4'd4, 32'h0F0F_3C3C, 1'b1);
        wr(4'd5, 32'h0, 1'b1);
        rd(4'd4, 1'b1, r); chk("R5 zero write", r, 32'h0F0F_3C3C);
        rd(4'd5, 1'b1, r); chk("R5 reads zero", r, 32'h0);
        wr(4'd5, 32'hFFFF_FFFF, 1'b1);

        // R7 quiet with nothing enabled
        src_lines = 32'hFFFF_FFFF;
        chk_irq("R7 quiet");

        // R6 R7 one-hot routing both ways, R11 level clearing
        for (int i = 0; i < 32; i++) begin
            src_lines = 32'h1 << i;
            wr(4'd4, 32'h1 << i, 1'b1);
            wr(4'd3, (i % 2 == 0) ? 32'h0 : 32'hFFFF_FFFF, 1'b1);
            chk_irq("R6 R7 onehot");
            wr(4'd3, ~rt_m, 1'b1);
            chk_irq("R6 R7 onehot swap");
            @(negedge clk); src_lines = 32'h0;
            chk_irq("R11 line drop");
            src_lines = 32'h1 << i;
            wr(4'd5, 32'h1 << i, 1'b1);
            chk_irq("R11 enable clear");
        end

        // Pseudo-random status patterns
        seed = 32'h1234_5678;
        for (int k = 0; k < 24; k++) begin
            seed = seed * 32'h41C6_4E6D + 32'h3039;
            wr(4'd5, 32'hFFFF_FFFF, 1'b1);
            wr(4'd4, seed ^ 32'h5A5A_A5A5, 1'b1);
            seed = seed * 32'h41C6_4E6D + 32'h3039;
            wr(4'd3, seed, 1'b1);
            rd(4'd3, 1'b1, r); chk("R6 route readback", r, rt_m);
            seed = seed * 32'h41C6_4E6D + 32'h3039;
            @(negedge clk); src_lines = seed;
            chk_status("pattern");
            chk_irq("R7 pattern");
        end

        // R9 guard
        src_lines = 32'h0;
        wr(4'd5, 32'hFFFF_FFFF, 1'b1);
        wr(4'd3, 32'h0, 1'b1);
        wr(4'd8, 32'h1, 1'b1);
        rd(4'd8, 1'b1, r); chk("R9 guard set", r, 32'h1);
        wr(4'd4, 32'h0000_00F0, 1'b0);
        rd(4'd4, 1'b1, r); chk("R9 user set ignored", r, 32'h0);
        wr(4'd3, 32'hFFFF_0000, 1'b0);
        rd(4'd3, 1'b1, r); chk("R9 user route ignored", r, 32'h0);
        wr(4'd4, 32'h0000_0300, 1'b1);
        rd(4'd4, 1'b0, r); chk("R9 user read zero", r, 32'h0);
        rd(4'd4, 1'b1, r); chk("R9 priv read", r, 32'h0000_0300);
        wr(4'd5, 32'h0000_0300, 1'b0);
        rd(4'd4, 1'b1, r); chk("R9 user clear ignored", r, 32'h0000_0300);
        wr(4'd8, 32'h0, 1'b0);
        rd(4'd8, 1'b1, r); chk("R9 user unguard ignored", r, 32'h1);
        wr(4'd8, 32'h0, 1'b1);
        rd(4'd8, 1'b0, r); chk("R9 priv unguard", r, 32'h0);
        wr(4'd4, 32'h0000_0001, 1'b0);
        rd(4'd4, 1'b0, r); chk("R9 user open access", r, 32'h0000_0301);

        // R10 unmapped reads and read-only writes
        src_lines = 32'hC001_D00D;
        for (int a = 6; a < 16; a++) begin
            if (a != 8) begin
                rd(a[3:0], 1'b1, r); chk("R10 unmapped read", r, 32'h0);
            end
        end
        wr(4'd0, 32'hFFFF_FFFF, 1'b1);
        wr(4'd1, 32'hFFFF_FFFF, 1'b1);
        wr(4'd2, 32'h0, 1'b1);
        rd(4'd4, 1'b1, r); chk("R10 ro write enable", r, en_m);
        rd(4'd3, 1'b1, r); chk("R10 ro write route", r, rt_m);
        chk_status("R10 ro write");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule